// File: doc/BRIEF.md
# Multi-Pulse PWM Channel

This block is a single pulse-width-modulation channel that can place up to four pulses, or eight output edges, inside one period. A 16-bit period counter is advanced by a tick from an 8-bit clock divider. Eight 16-bit compare values each mark a count at which the output flips. An enable mask decides which of those compares take part. At the start of every period the output is loaded with a programmable starting level, so one configuration describes a fixed waveform shape.

A rising trigger while the channel is armed but idle starts a period. In repeat mode the channel then runs period after period until it is disarmed. In one-shot mode it stops after a single period and waits for the next trigger. The pin can be forced to the starting level while the counter keeps running. A one-clock event pulse marks the end of each period.

Top module: `mpwm_channel`

## Requirements
- R1: While `rst` is high, `pwm_out` and `irq_out` are 0 and the channel is idle. After reset, `pwm_out` follows `init_level` while the channel is idle.
- R2: With `run_en` high and the channel idle, a clock with `trig` high starts a period with the counter at 0. The level becomes `init_level`, inverted once for each enabled compare equal to 0.
- R3: A `prescale_div` value N advances the counter once every N+1 clocks. N=0 advances it on every clock.
- R4: The counter counts 0, 1, ... up to `period`, then wraps to 0. One period therefore lasts `period`+1 counter steps.
- R5: Each time the counter steps onto a value, the level flips once for each enabled compare equal to that value. Compare i sits in `cmp_values[16*i+15:16*i]` and is enabled by `cmp_enable[i]`. Disabled compares have no effect, and compares above `period` never match.
- R6: On a wrap in repeat mode, the level is reloaded from `init_level`, with compares equal to 0 applied as in R2.
- R7: When `out_en` is low, `pwm_out` shows `init_level` from the next clock on, while the counter and level keep running. Raising `out_en` again shows the running waveform.
- R8: `irq_out` is high for exactly the one clock after each wrap, and only when a period ended there.
- R9: With `single_mode`=1, the channel goes idle at the wrap and `pwm_out` returns to `init_level`. A trigger during a running period is ignored. A later trigger starts a new period.
- R10: With `single_mode`=0, periods repeat back to back without a new trigger.
- R11: Dropping `run_en` stops the channel at the next clock, clears the counter and prescaler, and drives `init_level`.
- R12: Two enabled compares with the same value flip the level twice at that count, so they leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| run_en | input | 1 | Arms the channel; low stops and clears it |
| single_mode | input | 1 | 1: one period per trigger; 0: repeat |
| prescale_div | input | 8 | Divider value N; counter steps every N+1 clocks |
| period | input | 16 | Last counter value before wrap |
| cmp_values | input | 128 | Eight 16-bit compare values, compare i at bits 16*i+15:16*i |
| cmp_enable | input | 8 | Per-compare enable mask |
| init_level | input | 1 | Output level loaded at period start |
| out_en | input | 1 | Pin enable; low forces init_level |
| trig | input | 1 | Starts a period when armed and idle |
| pwm_out | output | 1 | Registered PWM output |
| irq_out | output | 1 | One-clock end-of-period pulse |

## Verification
On every cycle the assertions check that the counter takes single steps between wraps and that a one-shot channel drops to idle at its wrap. They also check that divider ticks are spaced apart when N is nonzero, that the event pulse only follows a running cycle, and that a disabled pin shows the starting level. The exact toggle counts, the effect of masked, coincident and out-of-range compares, the divided period length, the ignored mid-period trigger and the restart after disarm can only be shown by the scenarios. In those scenarios the bench compares the pin and the event pulse against a cycle model built from the requirements.

// File: rtl/mpwm_pkg.sv
package mpwm_pkg;
  localparam int unsigned DEF_CNT_W = 16;
  localparam int unsigned DEF_PRE_W = 8;
  localparam int unsigned DEF_NUM_CMP = 8;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } run_state_e;
endpackage

// File: rtl/mpwm_prescale.sv
module mpwm_prescale #(
  parameter int unsigned PRE_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             active,
  input  logic [PRE_W-1:0] div,
  output logic             tick
);
  logic [PRE_W-1:0] pre_q;

  assign tick = active && (pre_q == div);

  always_ff @(posedge clk) begin
    if (rst || !active) begin
      pre_q <= '0;
    end else if (pre_q == div) begin
      pre_q <= '0;
    end else begin
      pre_q <= pre_q + 1'b1;
    end
  end

  // R3: with a nonzero divider two ticks never come back to back
  p_tick_gap_r3: assert property (@(posedge clk) disable iff (rst)
    (tick && div != '0) |=> (!tick || div == '0));
endmodule

// File: rtl/mpwm_counter.sv
module mpwm_counter
  import mpwm_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run_en,
  input  logic             single_mode,
  input  logic             trig,
  input  logic             tick,
  input  logic [CNT_W-1:0] period,
  output logic             running,
  output logic [CNT_W-1:0] cnt_next,
  output logic             start,
  output logic             wrap,
  output logic             advance
);
  run_state_e state_q, state_d;
  logic [CNT_W-1:0] cnt_q;
  logic at_top;

  assign running = (state_q == ST_RUN);
  assign at_top  = (cnt_q == period);
  assign start   = !running && run_en && trig;
  assign wrap    = running && run_en && tick && at_top;
  assign advance = running && run_en && tick && !at_top;

  always_comb begin
    cnt_next = cnt_q;
    state_d  = state_q;
    if (!run_en) begin
      cnt_next = '0;
      state_d  = ST_IDLE;
    end else if (start) begin
      cnt_next = '0;
      state_d  = ST_RUN;
    end else if (wrap) begin
      cnt_next = '0;
      if (single_mode) state_d = ST_IDLE;
    end else if (advance) begin
      cnt_next = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      state_q <= ST_IDLE;
    end else begin
      cnt_q   <= cnt_next;
      state_q <= state_d;
    end
  end

  // R4: below the top value a tick moves the count by exactly one
  p_cnt_step_r4: assert property (@(posedge clk) disable iff (rst)
    (running && run_en && tick && cnt_q != period) |=> (cnt_q == CNT_W'($past(cnt_q) + 1'b1)));

  // R9: a one-shot period ends in idle
  p_single_stop_r9: assert property (@(posedge clk) disable iff (rst)
    (running && run_en && single_mode && tick && cnt_q == period) |=> !running);
endmodule

// File: rtl/mpwm_match.sv
module mpwm_match #(
  parameter int unsigned CNT_W   = 16,
  parameter int unsigned NUM_CMP = 8
) (
  input  logic [NUM_CMP*CNT_W-1:0] cmp_values,
  input  logic [NUM_CMP-1:0]       cmp_enable,
  input  logic [CNT_W-1:0]         value,
  output logic                     flip
);
  logic [NUM_CMP-1:0] hit;

  for (genvar i = 0; i < NUM_CMP; i++) begin : g_cmp
    assign hit[i] = cmp_enable[i] && (cmp_values[i*CNT_W +: CNT_W] == value);
  end

  assign flip = ^hit;
endmodule

// File: rtl/mpwm_channel.sv
module mpwm_channel
  import mpwm_pkg::*;
#(
  parameter int unsigned CNT_W   = DEF_CNT_W,
  parameter int unsigned PRE_W   = DEF_PRE_W,
  parameter int unsigned NUM_CMP = DEF_NUM_CMP
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     run_en,
  input  logic                     single_mode,
  input  logic [PRE_W-1:0]         prescale_div,
  input  logic [CNT_W-1:0]         period,
  input  logic [NUM_CMP*CNT_W-1:0] cmp_values,
  input  logic [NUM_CMP-1:0]       cmp_enable,
  input  logic                     init_level,
  input  logic                     out_en,
  input  logic                     trig,
  output logic                     pwm_out,
  output logic                     irq_out
);
  logic running, tick, start, wrap, advance, flip;
  logic [CNT_W-1:0] cnt_next;
  logic lvl_q, lvl_d, pwm_q, irq_q;

  mpwm_prescale #(.PRE_W(PRE_W)) u_pre (
    .clk    (clk),
    .rst    (rst),
    .active (running && run_en),
    .div    (prescale_div),
    .tick   (tick)
  );

  mpwm_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk         (clk),
    .rst         (rst),
    .run_en      (run_en),
    .single_mode (single_mode),
    .trig        (trig),
    .tick        (tick),
    .period      (period),
    .running     (running),
    .cnt_next    (cnt_next),
    .start       (start),
    .wrap        (wrap),
    .advance     (advance)
  );

  mpwm_match #(.CNT_W(CNT_W), .NUM_CMP(NUM_CMP)) u_match (
    .cmp_values (cmp_values),
    .cmp_enable (cmp_enable),
    .value      (cnt_next),
    .flip       (flip)
  );

  always_comb begin
    lvl_d = lvl_q;
    if (!run_en) begin
      lvl_d = init_level;
    end else if (start) begin
      lvl_d = init_level ^ flip;
    end else if (wrap) begin
      lvl_d = single_mode ? init_level : (init_level ^ flip);
    end else if (advance) begin
      lvl_d = lvl_q ^ flip;
    end else if (!running) begin
      lvl_d = init_level;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lvl_q <= 1'b0;
      pwm_q <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      lvl_q <= lvl_d;
      pwm_q <= out_en ? lvl_d : init_level;
      irq_q <= wrap;
    end
  end

  assign pwm_out = pwm_q;
  assign irq_out = irq_q;

  // R8: an end-of-period pulse only follows a running cycle
  p_irq_running_r8: assert property (@(posedge clk) disable iff (rst)
    irq_out |-> $past(running));

  // R7: a disabled pin shows the starting level one clock later
  p_oe_off_init_r7: assert property (@(posedge clk) disable iff (rst)
    !out_en |=> (pwm_out == $past(init_level)));
endmodule

// File: tb/mpwm_channel_test.sv
module mpwm_channel_test;
  localparam int CW = 16;
  localparam int PW = 8;
  localparam int NC = 8;
  localparam time CLK_HALF = 10ns;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic run_en = 1'b0, single_mode = 1'b0, init_level = 1'b0, out_en = 1'b1, trig = 1'b0;
  logic [PW-1:0] prescale_div = '0;
  logic [CW-1:0] period = '0;
  logic [NC*CW-1:0] cmp_values = '0;
  logic [NC-1:0] cmp_enable = '0;
  logic pwm_out, irq_out;

  int total = 0;
  int bad = 0;
  string cur_tag = "R1";

  logic [1:0] exp_q[$];
  string tag_q[$];

  logic m_run, m_lvl, m_pwm, m_irq;
  logic [CW-1:0] m_cnt;
  logic [PW-1:0] m_pre;

  always #(CLK_HALF) clk = ~clk;

  mpwm_channel uut (
    .clk(clk), .rst(rst), .run_en(run_en), .single_mode(single_mode),
    .prescale_div(prescale_div), .period(period), .cmp_values(cmp_values),
    .cmp_enable(cmp_enable), .init_level(init_level), .out_en(out_en),
    .trig(trig), .pwm_out(pwm_out), .irq_out(irq_out)
  );

  function automatic logic par(input logic [CW-1:0] v);
    logic p = 1'b0;
    for (int i = 0; i < NC; i++)
      if (cmp_enable[i] && cmp_values[i*CW +: CW] == v) p = ~p;
    return p;
  endfunction

  task automatic check(input string tag, input logic [1:0] act, input logic [1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: pwm/irq actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  // monitor: pops one expected item per clock
  always @(posedge clk) begin
    #2;
    if (exp_q.size() > 0) begin
      logic [1:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check(t, {pwm_out, irq_out}, e);
    end
  end

  // driver: model one clock from the requirements, push expectation, advance
  task automatic step();
    m_irq = 1'b0;
    if (!run_en) begin
      m_run = 0; m_cnt = 0; m_pre = 0; m_lvl = init_level;
    end else if (!m_run) begin
      if (trig) begin
        m_run = 1; m_cnt = 0; m_pre = 0; m_lvl = init_level ^ par('0);
      end else m_lvl = init_level;
    end else if (m_pre == prescale_div) begin
      m_pre = 0;
      if (m_cnt == period) begin
        m_cnt = 0; m_irq = 1'b1;
        if (single_mode) begin m_run = 0; m_lvl = init_level; end
        else m_lvl = init_level ^ par('0);
      end else begin
        m_cnt = m_cnt + 1'b1;
        m_lvl = m_lvl ^ par(m_cnt);
      end
    end else m_pre = m_pre + 1'b1;
    m_pwm = out_en ? m_lvl : init_level;
    exp_q.push_back({m_pwm, m_irq});
    tag_q.push_back(cur_tag);
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic steps(input int n);
    for (int k = 0; k < n; k++) step();
  endtask

  task automatic pulse_trig();
    trig = 1'b1; step(); trig = 1'b0;
  endtask

  task automatic set_cmp(input int i, input int v, input logic en);
    cmp_values[i*CW +: CW] = CW'(v);
    cmp_enable[i] = en;
  endtask

  initial begin
    #(CLK_HALF * 2 * 200000);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    init_level = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1", {pwm_out, irq_out}, 2'b00);
    rst = 1'b0;
    m_run = 0; m_cnt = 0; m_pre = 0; m_lvl = 0;
    cur_tag = "R1"; steps(3);
    init_level = 1'b0;

    // R4 R5 R10: eight edges, no division, repeating
    cur_tag = "R5";
    period = 23;
    set_cmp(0, 7, 1); set_cmp(1, 8, 1); set_cmp(2, 12, 1); set_cmp(3, 14, 1);
    set_cmp(4, 15, 1); set_cmp(5, 16, 1); set_cmp(6, 19, 1); set_cmp(7, 22, 1);
    run_en = 1'b1; steps(2);
    cur_tag = "R2"; pulse_trig();
    cur_tag = "R10"; steps(80);

    // R3 R6: divider 2, starting level 1
    run_en = 1'b0; step();
    cur_tag = "R3";
    prescale_div = 2; period = 9; init_level = 1'b1; cmp_enable = '0;
    set_cmp(0, 2, 1); set_cmp(1, 5, 1);
    run_en = 1'b1; pulse_trig();
    cur_tag = "R6"; steps(70);

    // R5: masked compares and compares above period
    run_en = 1'b0; step();
    cur_tag = "R5";
    prescale_div = 0; period = 10; init_level = 1'b0; cmp_enable = '0;
    set_cmp(0, 3, 1); set_cmp(1, 4, 0); set_cmp(2, 6, 1); set_cmp(3, 30, 1); set_cmp(4, 8, 0);
    run_en = 1'b1; pulse_trig(); steps(35);

    // R12: coincident compares cancel; R2: compare at 0
    run_en = 1'b0; step();
    cur_tag = "R12";
    cmp_enable = '0;
    set_cmp(0, 4, 1); set_cmp(1, 4, 1); set_cmp(2, 6, 1); set_cmp(3, 0, 1);
    run_en = 1'b1; pulse_trig(); steps(30);

    // R7: pin disabled then re-enabled mid-period
    cur_tag = "R7";
    out_en = 1'b0; steps(9);
    out_en = 1'b1; steps(9);

    // R9: one-shot, trigger during run ignored, retrigger
    run_en = 1'b0; step();
    cur_tag = "R9";
    single_mode = 1'b1; prescale_div = 1; period = 5; cmp_enable = '0;
    set_cmp(0, 2, 1); set_cmp(1, 4, 1);
    run_en = 1'b1; pulse_trig(); steps(3);
    pulse_trig(); steps(12);
    pulse_trig(); steps(16);

    // R11: disarm mid-period, then restart
    cur_tag = "R11";
    single_mode = 1'b0; prescale_div = 0; period = 12;
    pulse_trig(); steps(5);
    run_en = 1'b0; steps(4);
    run_en = 1'b1; steps(2); pulse_trig(); steps(15);

    // R8: period 0, no division, pulse every clock
    run_en = 1'b0; step();
    cur_tag = "R8";
    period = 0; cmp_enable = '0;
    run_en = 1'b1; pulse_trig(); steps(6);

    steps(1);
    @(posedge clk); #5;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule